// File: doc/BRIEF.md
# Fractional-N Divider Chain

This block takes a fast VCO clock and a fixed reference clock and divides each down to a common compare rate for a phase-frequency detector. The reference side uses a constant ratio. The VCO side is a down-counter. At the end of every compare period it reloads with an integer modulus plus a small signed per-period offset. That offset comes from an external noise-shaping modulator. The long-run average division ratio therefore takes fractional values.

A multi-stage accumulator needs time for its next output to settle. The block helps by raising a step strobe a fixed number of VCO cycles before each reload. The modulator advances on this strobe, and its new offset is stable by the time the divider samples it. Frequency words arrive MSB first on a serial port and are captured by a separate load pulse. They take effect only on a reload cycle, so a compare period never mixes an old value with a new one.

The VCO divider is a four-state machine:
- ST_COUNT counts down while the counter is above the lead point. It moves to ST_STROBE when the next count equals LEAD+1.
- ST_STROBE lasts one cycle and raises the step strobe. It moves to ST_TAIL, or straight to ST_RELOAD when LEAD is 1.
- ST_TAIL counts down the remaining lead cycles. It moves to ST_RELOAD when the next count is 1.
- ST_RELOAD raises the terminal count and loads the clamped modulus. It returns to ST_COUNT, or to ST_STROBE when the new modulus is exactly LEAD+1.

Top module: `fnd_chain`

## Requirements
- R1: Reset state and first period.
  - While reset is held, vco_tc, ref_tc, mod_step and clamp_err are 0, and frac_word equals F_RST (default 0).
  - After reset is released, the first vco_tc appears after N_RST-1 rising vco_clk edges (default 39).
- R2: ref_tc is high for exactly one ref_clk cycle in every REF_DIV cycles (default 100).
- R3: vco_tc is one vco_clk cycle wide.
  - The spacing from one vco_tc to the next equals N+dn. Here N is the active integer word and dn is mod_dn, a 4-bit two's-complement value sampled on the edge that ends the earlier vco_tc cycle.
- R4: Within every compare period, mod_step is high for exactly one cycle, exactly LEAD cycles (default 4) before vco_tc. The two are never high together.
- R5: Control-word format and hold.
  - The serial word is 24 bits, shifted in MSB first while ctl_shift is high. N is bits 23:16 and F is bits 15:0.
  - frac_word changes only on the edge that ends a vco_tc cycle.
- R6: Applying a loaded word.
  - A word loaded mid-period drives the period that follows the next reload: both its N and its frac_word.
  - When several loads land before one reload, the last one is used.
- R7: Clamping.
  - The reload modulus is clamped to the range from max(MOD_MIN, LEAD+1) to MOD_MAX (default 8 to 255).
  - clamp_err is high for the one cycle after a reload that clamped, and is low otherwise.
- R8: Shifting bits without a load pulse changes neither the period nor frac_word.
- R9: A load pulse in the same cycle as vco_tc is not applied at that reload. It is applied at the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO-rate clock |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_shift | input | 1 | Shift-enable for the serial control port |
| ctl_sdi | input | 1 | Serial control data, MSB first |
| ctl_load | input | 1 | Captures the shifted word as pending |
| mod_dn | input | DN_W | Signed per-period offset from the modulator |
| mod_step | output | 1 | Advance strobe for the modulator, LEAD cycles before reload |
| frac_word | output | F_W | Active fractional word for the modulator |
| vco_tc | output | 1 | VCO divider terminal-count pulse |
| ref_tc | output | 1 | Reference divider terminal-count pulse |
| clamp_err | output | 1 | Reload modulus was clamped |

## Verification
The assertions check the following on every cycle:
- both terminal counts are single-cycle pulses;
- the reference spacing is constant;
- each vco_tc trails mod_step by exactly LEAD cycles;
- every VCO period lies within the legal modulus range;
- frac_word moves only right after a reload;
- clamp_err appears only after a reload.

Only the bench scenarios can show the following:
- that each period equals the clamped sum of the intended N and offset;
- which reload a loaded word lands on, including a load that coincides with vco_tc and back-to-back loads;
- that a shift without a load leaves everything unchanged.

// File: rtl/fnd_pkg.sv
`timescale 1ns/1ps
package fnd_pkg;
    typedef enum logic [1:0] {
        ST_COUNT  = 2'd0,
        ST_STROBE = 2'd1,
        ST_TAIL   = 2'd2,
        ST_RELOAD = 2'd3
    } div_state_e;
endpackage

// File: rtl/fnd_ref_div.sv
`timescale 1ns/1ps
module fnd_ref_div #(
    parameter int REF_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tc
);
    localparam int RW = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
    localparam logic [RW-1:0] TOP = RW'(REF_DIV - 1);

    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= TOP;
        else if (cnt_q == '0)
            cnt_q <= TOP;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    always_comb tc = rst_n && (cnt_q == '0);
endmodule

// File: rtl/fnd_ctl_port.sv
`timescale 1ns/1ps
module fnd_ctl_port #(
    parameter int N_W   = 8,
    parameter int F_W   = 16,
    parameter int N_RST = 40,
    parameter int F_RST = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           sdi,
    input  logic           load,
    input  logic           reload,
    output logic [N_W-1:0] n_use,
    output logic [F_W-1:0] frac_word
);
    localparam int CW_W = N_W + F_W;
    localparam logic [CW_W-1:0] RST_WORD = {N_W'(N_RST), F_W'(F_RST)};

    logic [CW_W-1:0] sreg_q;
    logic [CW_W-1:0] pend_q;
    logic [CW_W-1:0] act_q;
    logic            pend_v_q;

    // Serial capture, MSB first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sreg_q <= '0;
        else if (shift_en)
            sreg_q <= {sreg_q[CW_W-2:0], sdi};
    end

    // Pending word waits for the next reload; a load coinciding with
    // a reload is held for the reload after it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            act_q    <= RST_WORD;
        end else begin
            if (reload && pend_v_q)
                act_q <= pend_q;
            if (load) begin
                pend_q   <= sreg_q;
                pend_v_q <= 1'b1;
            end else if (reload) begin
                pend_v_q <= 1'b0;
            end
        end
    end

    always_comb begin
        n_use     = (reload && pend_v_q) ? pend_q[CW_W-1:F_W] : act_q[CW_W-1:F_W];
        frac_word = act_q[F_W-1:0];
    end
endmodule

// File: rtl/fnd_vco_div.sv
`timescale 1ns/1ps
module fnd_vco_div
    import fnd_pkg::*;
#(
    parameter int N_W    = 8,
    parameter int DN_W   = 4,
    parameter int LEAD   = 4,
    parameter int MOD_LO = 8,
    parameter int MOD_HI = 255,
    parameter int N_RST  = 40
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_W-1:0]         n_use,
    input  logic signed [DN_W-1:0] dn,
    output logic                   tc,
    output logic                   step,
    output logic                   clamp_err
);
    localparam int CNT_W = $clog2(MOD_HI + 1);
    localparam logic [CNT_W-1:0] LEAD1 = CNT_W'(LEAD + 1);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] LO_V  = CNT_W'(MOD_LO);
    localparam logic [CNT_W-1:0] HI_V  = CNT_W'(MOD_HI);

    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] mod_nxt;
    logic             clip;
    logic             err_q;
    int               sum_i;

    // Modulus for the next period, clamped to the legal window
    always_comb begin
        sum_i = int'(n_use) + int'(dn);
        clip  = 1'b0;
        if (sum_i < MOD_LO) begin
            mod_nxt = LO_V;
            clip    = 1'b1;
        end else if (sum_i > MOD_HI) begin
            mod_nxt = HI_V;
            clip    = 1'b1;
        end else begin
            mod_nxt = CNT_W'(sum_i);
        end
    end

    // Next state and count
    always_comb begin
        cnt_d   = cnt_q - 1'b1;
        state_d = state_q;
        unique case (state_q)
            ST_RELOAD: begin
                cnt_d   = mod_nxt;
                state_d = (mod_nxt == LEAD1) ? ST_STROBE : ST_COUNT;
            end
            ST_COUNT: begin
                state_d = (cnt_d == LEAD1) ? ST_STROBE : ST_COUNT;
            end
            ST_STROBE: begin
                state_d = (cnt_d == ONE) ? ST_RELOAD : ST_TAIL;
            end
            ST_TAIL: begin
                state_d = (cnt_d == ONE) ? ST_RELOAD : ST_TAIL;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
            cnt_q   <= CNT_W'(N_RST);
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            err_q   <= (state_q == ST_RELOAD) && clip;
        end
    end

    // Outputs
    always_comb begin
        tc        = (state_q == ST_RELOAD);
        step      = (state_q == ST_STROBE);
        clamp_err = err_q;
    end
endmodule

// File: rtl/fnd_chain.sv
`timescale 1ns/1ps
module fnd_chain #(
    parameter int N_W     = 8,
    parameter int F_W     = 16,
    parameter int DN_W    = 4,
    parameter int LEAD    = 4,
    parameter int MOD_MIN = 8,
    parameter int MOD_MAX = 255,
    parameter int N_RST   = 40,
    parameter int F_RST   = 0,
    parameter int REF_DIV = 100
) (
    input  logic                   vco_clk,
    input  logic                   ref_clk,
    input  logic                   rst_n,
    input  logic                   ctl_shift,
    input  logic                   ctl_sdi,
    input  logic                   ctl_load,
    input  logic signed [DN_W-1:0] mod_dn,
    output logic                   mod_step,
    output logic [F_W-1:0]         frac_word,
    output logic                   vco_tc,
    output logic                   ref_tc,
    output logic                   clamp_err
);
    localparam int MOD_LO = (MOD_MIN > LEAD) ? MOD_MIN : LEAD + 1;

    logic [N_W-1:0] n_use;

    fnd_ctl_port #(
        .N_W(N_W), .F_W(F_W), .N_RST(N_RST), .F_RST(F_RST)
    ) u_ctl (
        .clk(vco_clk), .rst_n(rst_n), .shift_en(ctl_shift), .sdi(ctl_sdi),
        .load(ctl_load), .reload(vco_tc), .n_use(n_use), .frac_word(frac_word)
    );

    fnd_vco_div #(
        .N_W(N_W), .DN_W(DN_W), .LEAD(LEAD), .MOD_LO(MOD_LO),
        .MOD_HI(MOD_MAX), .N_RST(N_RST)
    ) u_vdiv (
        .clk(vco_clk), .rst_n(rst_n), .n_use(n_use), .dn(mod_dn),
        .tc(vco_tc), .step(mod_step), .clamp_err(clamp_err)
    );

    fnd_ref_div #(
        .REF_DIV(REF_DIV)
    ) u_rdiv (
        .clk(ref_clk), .rst_n(rst_n), .tc(ref_tc)
    );
endmodule

// File: rtl/fnd_chain_chk.sv
`timescale 1ns/1ps
module fnd_chain_chk #(
    parameter int F_W     = 16,
    parameter int LEAD    = 4,
    parameter int MOD_LO  = 8,
    parameter int MOD_HI  = 255,
    parameter int REF_DIV = 100
) (
    input logic           vco_clk,
    input logic           ref_clk,
    input logic           rst_n,
    input logic           mod_step,
    input logic [F_W-1:0] frac_word,
    input logic           vco_tc,
    input logic           ref_tc,
    input logic           clamp_err
);
    localparam int SAT = 1 << 20;

    int   since_step;
    int   vgap;
    logic vseen;
    int   rgap;
    logic rseen;

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) begin
            since_step <= 0;
            vgap       <= 0;
            vseen      <= 1'b0;
        end else begin
            if (mod_step)
                since_step <= 1;
            else if (since_step != 0 && since_step < SAT)
                since_step <= since_step + 1;
            if (vco_tc)
                vgap <= 1;
            else if (vgap < SAT)
                vgap <= vgap + 1;
            if (vco_tc)
                vseen <= 1'b1;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            rgap  <= 0;
            rseen <= 1'b0;
        end else begin
            if (ref_tc)
                rgap <= 1;
            else if (rgap < SAT)
                rgap <= rgap + 1;
            if (ref_tc)
                rseen <= 1'b1;
        end
    end

    AST_TC_SINGLE: assert property (@(posedge vco_clk) disable iff (!rst_n)
        vco_tc |=> !vco_tc); // R3
    AST_STEP_LEAD: assert property (@(posedge vco_clk) disable iff (!rst_n)
        vco_tc |-> (since_step == LEAD)); // R4
    AST_STEP_APART: assert property (@(posedge vco_clk) disable iff (!rst_n)
        !(mod_step && vco_tc)); // R4
    AST_PERIOD_RANGE: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (vco_tc && vseen) |-> (vgap >= MOD_LO && vgap <= MOD_HI)); // R7
    AST_CLAMP_AFTER_TC: assert property (@(posedge vco_clk) disable iff (!rst_n)
        clamp_err |-> $past(vco_tc)); // R7
    AST_FRAC_HOLD: assert property (@(posedge vco_clk) disable iff (!rst_n)
        !vco_tc |=> $stable(frac_word)); // R5
    AST_REF_SINGLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ref_tc |=> !ref_tc); // R2
    AST_REF_PERIOD: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (ref_tc && rseen) |-> (rgap == REF_DIV)); // R2
endmodule

bind fnd_chain fnd_chain_chk #(
    .F_W(F_W), .LEAD(LEAD), .MOD_LO(MOD_LO), .MOD_HI(MOD_MAX), .REF_DIV(REF_DIV)
) u_chk (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .mod_step(mod_step),
    .frac_word(frac_word), .vco_tc(vco_tc), .ref_tc(ref_tc), .clamp_err(clamp_err)
);

// File: tb/sim_fnd_chain.sv
`timescale 1ns/1ps
module sim_fnd_chain;
    localparam int LEAD = 4;
    localparam int LO   = 8;
    localparam int HI   = 255;
    localparam int RDIV = 100;

    logic              vco_clk = 1'b0;
    logic              ref_clk = 1'b0;
    logic              rst_n   = 1'b0;
    logic              ctl_shift = 1'b0;
    logic              ctl_sdi   = 1'b0;
    logic              ctl_load  = 1'b0;
    logic signed [3:0] mod_dn    = '0;
    logic              mod_step;
    logic [15:0]       frac_word;
    logic              vco_tc;
    logic              ref_tc;
    logic              clamp_err;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #4 vco_clk = ~vco_clk;
    always #5 ref_clk = ~ref_clk;

    fnd_chain u0 (
        .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n),
        .ctl_shift(ctl_shift), .ctl_sdi(ctl_sdi), .ctl_load(ctl_load),
        .mod_dn(mod_dn), .mod_step(mod_step), .frac_word(frac_word),
        .vco_tc(vco_tc), .ref_tc(ref_tc), .clamp_err(clamp_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampm(input int v);
        return (v < LO) ? LO : ((v > HI) ? HI : v);
    endfunction

    // Monitor: VCO periods against the scoreboard, and strobe lead time
    int cyc = 0, last_tc = 0, last_step = 0;
    bit have_tc = 1'b0, have_step = 1'b0;
    always @(negedge vco_clk) begin
        if (rst_n) begin
            cyc++;
            if (mod_step && vco_tc) chk(1'b0, "R4", 1, 0);
            if (mod_step) begin
                last_step = cyc;
                have_step = 1'b1;
            end
            if (vco_tc) begin
                if (have_step) chk(cyc - last_step == LEAD, "R4", cyc - last_step, LEAD);
                if (have_tc && exp_q.size() > 0) begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(cyc - last_tc == e, t, cyc - last_tc, e);
                end
                last_tc = cyc;
                have_tc = 1'b1;
            end
        end
    end

    // Monitor: reference divider spacing (R2)
    int rcyc = 0, rlast = 0;
    bit rhave = 1'b0;
    always @(negedge ref_clk) begin
        if (rst_n) begin
            rcyc++;
            if (ref_tc) begin
                if (rhave) chk(rcyc - rlast == RDIV, "R2", rcyc - rlast, RDIV);
                rlast = rcyc;
                rhave = 1'b1;
            end
        end
    end

    task automatic wait_tc();
        do @(negedge vco_clk); while (!vco_tc);
        #1;
    endtask

    // Driver: set the offset at a reload and queue the expected period
    task automatic period(input int dn, input int n, input string tag);
        int s;
        wait_tc();
        mod_dn = 4'(dn);
        s = n + dn;
        exp_q.push_back(clampm(s));
        tag_q.push_back(tag);
        @(negedge vco_clk);
        chk(clamp_err == (s != clampm(s)), "R7", int'(clamp_err), int'(s != clampm(s)));
    endtask

    task automatic send_word(input int n, input int f, input bit do_load);
        logic [23:0] w;
        w = {8'(n), 16'(f)};
        for (int i = 23; i >= 0; i--) begin
            @(negedge vco_clk);
            ctl_shift = 1'b1;
            ctl_sdi   = w[i];
        end
        @(negedge vco_clk);
        ctl_shift = 1'b0;
        ctl_load  = do_load;
        @(negedge vco_clk);
        ctl_load  = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int k;
        // R1: reset state
        repeat (3) @(negedge vco_clk);
        chk(vco_tc == 1'b0 && mod_step == 1'b0 && clamp_err == 1'b0 && ref_tc == 1'b0,
            "R1", int'({vco_tc, mod_step, clamp_err, ref_tc}), 0);
        chk(frac_word == 16'h0000, "R1", int'(frac_word), 0);
        rst_n = 1'b1;
        k = 0;
        while (!vco_tc) begin
            @(posedge vco_clk);
            k++;
            @(negedge vco_clk);
        end
        chk(k == 39, "R1", k, 39);

        // R3: several offsets around N=40
        period(0, 40, "R3");
        period(3, 40, "R3");
        period(-5, 40, "R3");
        period(7, 40, "R3");

        // R5/R6: mid-period load of N=60, F=A5C3
        period(0, 40, "R5");
        send_word(60, 16'hA5C3, 1'b1);
        chk(frac_word == 16'h0000, "R5", int'(frac_word), 0);
        wait_tc();
        chk(frac_word == 16'h0000, "R5", int'(frac_word), 0);
        mod_dn = '0;
        exp_q.push_back(60);
        tag_q.push_back("R6");
        @(negedge vco_clk);
        chk(frac_word == 16'hA5C3, "R6", int'(frac_word), 16'hA5C3);

        // R6: two loads before one reload, last one wins
        send_word(30, 16'h1111, 1'b1);
        send_word(25, 16'h2222, 1'b1);
        period(0, 25, "R6");
        chk(frac_word == 16'h2222, "R6", int'(frac_word), 16'h2222);

        // R8: shift only, no load
        send_word(90, 16'h3333, 1'b0);
        period(0, 25, "R8");
        chk(frac_word == 16'h2222, "R8", int'(frac_word), 16'h2222);

        // R9: load coinciding with vco_tc applies one reload later
        wait_tc();
        mod_dn   = '0;
        ctl_load = 1'b1;
        exp_q.push_back(25);
        tag_q.push_back("R9");
        @(negedge vco_clk);
        ctl_load = 1'b0;
        chk(frac_word == 16'h2222, "R9", int'(frac_word), 16'h2222);
        wait_tc();
        exp_q.push_back(90);
        tag_q.push_back("R9");
        @(negedge vco_clk);
        chk(frac_word == 16'h3333, "R9", int'(frac_word), 16'h3333);

        // R7: clamping at both ends
        period(-8, 90, "R7");
        send_word(10, 0, 1'b1);
        period(-8, 10, "R7");
        period(-3, 10, "R7");
        period(0, 10, "R7");
        send_word(250, 0, 1'b1);
        period(7, 250, "R7");
        period(-8, 250, "R7");

        while (exp_q.size() > 0) @(negedge vco_clk);
        repeat (5) @(negedge vco_clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule